// File: doc/BRIEF.md
# Clustered Page Table Walker

This block translates a virtual address by walking a hashed page table whose entries each cover a group of 16 neighbouring virtual pages. The page number is split into a group base, with its low four bits cleared, and a slot index, which is those four bits. Only the group base is sent out on a hash port. That port returns the head pointer of the matching bucket. The engine then follows the bucket's chain through a 64-bit word read port.

For each entry it visits, the engine first compares the stored group base. On a match it reads the entry's status word. That word holds a 16-bit per-slot valid bitmap, a 4-bit group size and 24 shared control bits. If the slot is populated, the engine fetches the physical frame number of that one slot and builds the physical address. A missing mapping, an empty slot, a slot beyond the group size, the end of the chain or an over-long chain each end the lookup as a page fault.

An entry starting at word pointer P uses the following layout:
- P+0 holds the group base in its low bits.
- P+1 holds the status word.
- P+2 to P+17 hold one frame number per slot.
- P+18 holds the next pointer.

A pointer of zero means "no entry". One lookup is in flight at a time.

Top module: `cpt_lookup_engine`

## Requirements
- R1: The hash key sent on `hash_key` is the page number `req_va[VA_W-1:12]` with its low 4 bits forced to zero. The slot index is the page number's low 4 bits.
- R2: On a hit, `rsp_pa` equals `{frame, req_va[11:0]}`. Here `frame` is bits [PFN_W-1:0] of word P+2+slot of the matching entry. `rsp_ctrl` equals bits [43:20] of word P+1.
- R3: If the group base matches but bit `slot` of the bitmap (bits [15:0] of word P+1) is 0, the result is a fault.
- R4: The size field, bits [19:16] of word P+1, holds the group page count minus one. A slot above that value gives a fault even when its bitmap bit is 1.
- R5: A hash pointer of zero, or a next pointer of zero (bits [ADDR_W-1:0] of word P+18) read after a base mismatch, gives a fault.
- R6: A base mismatch makes the engine read word P+18 and continue the walk at that pointer. A match further down the chain still gives a hit.
- R7: After MAX_DEPTH entries have been compared without a match, the walk stops with a fault and the next pointer is not read. A match at exactly depth MAX_DEPTH hits.
- R8: A hit found at chain depth d takes exactly 2d+1 memory reads. A chain exhausted at depth d takes 2d reads. A slot fault at depth d takes 2d reads.
- R9: After reset, and between lookups, the block is idle with `req_ready`=1 and no request on any port. `req_ready` is 0 while a lookup runs. Each result is a one-cycle `rsp_valid` pulse with exactly one of `rsp_hit` and `rsp_fault` set. On a fault, `rsp_pa` and `rsp_ctrl` are 0.
- R10: Once `mem_req` is raised, it and `mem_addr` hold steady until `mem_rsp_valid` is seen. The same holds for `hash_req` and `hash_key` until `hash_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Virtual address to translate |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| hash_req | output | 1 | Hash lookup wanted |
| hash_key | output | VA_W-12 | Group base page number |
| hash_rsp_valid | input | 1 | Hash result present |
| hash_ptr | input | ADDR_W | Bucket head pointer, zero for empty |
| mem_req | output | 1 | Word read wanted |
| mem_addr | output | ADDR_W | Word address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rdata | input | 64 | Read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Page fault |
| rsp_pa | output | PFN_W+12 | Physical address |
| rsp_ctrl | output | 24 | Shared control bits of the group |

## Verification
A corrupted chain pointer or a wrong word offset shows up at the ports in the same lookup. It appears as a read count that differs from 2d+1 or 2d, or as a wrong frame in `rsp_pa`, which the bench sees on the `rsp_valid` pulse. A mis-latched slot or page offset shows in the low bits of `rsp_pa`, or as a hit where a fault is due, within that one response. A stuck state shows as `req_ready` staying low, which ends the run through the watchdog.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

    localparam int unsigned GRP_BITS  = 4;
    localparam int unsigned GRP_PAGES = 1 << GRP_BITS;

    // word offsets inside one table entry
    localparam int unsigned WORD_BASE = 0;
    localparam int unsigned WORD_STAT = 1;
    localparam int unsigned WORD_PFN0 = 2;
    localparam int unsigned WORD_LINK = WORD_PFN0 + GRP_PAGES;

    // status word fields
    localparam int unsigned STAT_MAP_LSB  = 0;
    localparam int unsigned STAT_SIZE_LSB = STAT_MAP_LSB + GRP_PAGES;
    localparam int unsigned STAT_CTRL_LSB = STAT_SIZE_LSB + GRP_BITS;
    localparam int unsigned CTRL_W        = 24;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_HASH,
        WK_BASE,
        WK_STAT,
        WK_FRAME,
        WK_LINK,
        WK_DONE
    } walk_state_e;

endpackage

// File: rtl/cpt_va_split.sv
module cpt_va_split #(
    parameter int unsigned VA_W   = 48,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned GRP_W  = 4,
    localparam int unsigned VPN_W = VA_W - OFF_W
) (
    input  logic [VA_W-1:0]  va,
    output logic [VPN_W-1:0] grp_base,
    output logic [GRP_W-1:0] slot,
    output logic [OFF_W-1:0] page_off
);
    assign page_off = va[OFF_W-1:0];
    assign slot     = va[OFF_W +: GRP_W];
    assign grp_base = {va[VA_W-1:OFF_W+GRP_W], {GRP_W{1'b0}}};
endmodule

// File: rtl/cpt_slot_gate.sv
module cpt_slot_gate #(
    parameter int unsigned GRP_W    = 4,
    localparam int unsigned NSLOT   = 1 << GRP_W
) (
    input  logic [NSLOT-1:0] slot_map,
    input  logic [GRP_W-1:0] size_m1,
    input  logic [GRP_W-1:0] slot,
    output logic             slot_ok
);
    logic [NSLOT-1:0] pick;

    for (genvar g = 0; g < NSLOT; g++) begin : g_dec
        assign pick[g] = (slot == GRP_W'(g)) && slot_map[g];
    end

    assign slot_ok = (|pick) && (slot <= size_m1);
endmodule

// File: rtl/cpt_word_addr.sv
module cpt_word_addr
    import cpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned GRP_W  = 4
) (
    input  walk_state_e       st,
    input  logic [ADDR_W-1:0] ent_ptr,
    input  logic [GRP_W-1:0]  slot,
    output logic [ADDR_W-1:0] word_addr
);
    always_comb begin
        case (st)
            WK_STAT:  word_addr = ent_ptr + ADDR_W'(WORD_STAT);
            WK_FRAME: word_addr = ent_ptr + ADDR_W'(WORD_PFN0) + ADDR_W'(slot);
            WK_LINK:  word_addr = ent_ptr + ADDR_W'(WORD_LINK);
            default:  word_addr = ent_ptr + ADDR_W'(WORD_BASE);
        endcase
    end
endmodule

// File: rtl/cpt_lookup_engine.sv
module cpt_lookup_engine
    import cpt_pkg::*;
#(
    parameter int unsigned VA_W      = 48,
    parameter int unsigned PFN_W     = 40,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned MAX_DEPTH = 8,
    localparam int unsigned OFF_W    = 12,
    localparam int unsigned VPN_W    = VA_W - OFF_W,
    localparam int unsigned PA_W     = PFN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    output logic              req_ready,
    output logic              hash_req,
    output logic [VPN_W-1:0]  hash_key,
    input  logic              hash_rsp_valid,
    input  logic [ADDR_W-1:0] hash_ptr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [CTRL_W-1:0] rsp_ctrl
);
    localparam int unsigned GRP_W   = GRP_BITS;
    localparam int unsigned DEPTH_W = $clog2(MAX_DEPTH + 1);

    typedef struct packed {
        walk_state_e        st;
        logic [VPN_W-1:0]   base;
        logic [GRP_W-1:0]   slot;
        logic [OFF_W-1:0]   off;
        logic [ADDR_W-1:0]  ptr;
        logic [DEPTH_W-1:0] depth;
        logic               hit;
        logic [PFN_W-1:0]   frame;
        logic [CTRL_W-1:0]  ctrl;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [VPN_W-1:0] sp_base;
    logic [GRP_W-1:0] sp_slot;
    logic [OFF_W-1:0] sp_off;
    logic             slot_ok;
    logic             base_eq;
    logic             unused_rdata;

    cpt_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .GRP_W(GRP_W)) u_split (
        .va       (req_va),
        .grp_base (sp_base),
        .slot     (sp_slot),
        .page_off (sp_off)
    );

    cpt_slot_gate #(.GRP_W(GRP_W)) u_gate (
        .slot_map (mem_rdata[STAT_MAP_LSB +: GRP_PAGES]),
        .size_m1  (mem_rdata[STAT_SIZE_LSB +: GRP_W]),
        .slot     (walk_q.slot),
        .slot_ok  (slot_ok)
    );

    cpt_word_addr #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_addr (
        .st        (walk_q.st),
        .ent_ptr   (walk_q.ptr),
        .slot      (walk_q.slot),
        .word_addr (mem_addr)
    );

    assign base_eq      = (mem_rdata[VPN_W-1:0] == walk_q.base);
    assign unused_rdata = ^mem_rdata;

    always_comb begin
        walk_d = walk_q;
        case (walk_q.st)
            WK_IDLE: begin
                if (req_valid) begin
                    walk_d.base  = sp_base;
                    walk_d.slot  = sp_slot;
                    walk_d.off   = sp_off;
                    walk_d.depth = '0;
                    walk_d.hit   = 1'b0;
                    walk_d.frame = '0;
                    walk_d.ctrl  = '0;
                    walk_d.st    = WK_HASH;
                end
            end
            WK_HASH: begin
                if (hash_rsp_valid) begin
                    if (hash_ptr == '0) begin
                        walk_d.st = WK_DONE;
                    end else begin
                        walk_d.ptr   = hash_ptr;
                        walk_d.depth = DEPTH_W'(1);
                        walk_d.st    = WK_BASE;
                    end
                end
            end
            WK_BASE: begin
                if (mem_rsp_valid) begin
                    if (base_eq) begin
                        walk_d.st = WK_STAT;
                    end else if (walk_q.depth == DEPTH_W'(MAX_DEPTH)) begin
                        walk_d.st = WK_DONE;
                    end else begin
                        walk_d.st = WK_LINK;
                    end
                end
            end
            WK_STAT: begin
                if (mem_rsp_valid) begin
                    if (slot_ok) begin
                        walk_d.ctrl = mem_rdata[STAT_CTRL_LSB +: CTRL_W];
                        walk_d.st   = WK_FRAME;
                    end else begin
                        walk_d.st = WK_DONE;
                    end
                end
            end
            WK_FRAME: begin
                if (mem_rsp_valid) begin
                    walk_d.frame = mem_rdata[PFN_W-1:0];
                    walk_d.hit   = 1'b1;
                    walk_d.st    = WK_DONE;
                end
            end
            WK_LINK: begin
                if (mem_rsp_valid) begin
                    if (mem_rdata[ADDR_W-1:0] == '0) begin
                        walk_d.st = WK_DONE;
                    end else begin
                        walk_d.ptr   = mem_rdata[ADDR_W-1:0];
                        walk_d.depth = walk_q.depth + DEPTH_W'(1);
                        walk_d.st    = WK_BASE;
                    end
                end
            end
            default: begin
                walk_d.st = WK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready = (walk_q.st == WK_IDLE);
    assign hash_req  = (walk_q.st == WK_HASH);
    assign hash_key  = walk_q.base;
    assign mem_req   = (walk_q.st == WK_BASE) || (walk_q.st == WK_STAT) ||
                       (walk_q.st == WK_FRAME) || (walk_q.st == WK_LINK);
    assign rsp_valid = (walk_q.st == WK_DONE);
    assign rsp_hit   = rsp_valid && walk_q.hit;
    assign rsp_fault = rsp_valid && !walk_q.hit;
    assign rsp_pa    = rsp_hit ? {walk_q.frame, walk_q.off} : '0;
    assign rsp_ctrl  = rsp_hit ? walk_q.ctrl : '0;
endmodule

// File: rtl/cpt_lookup_checker.sv
module cpt_lookup_checker #(
    parameter int unsigned VA_W   = 48,
    parameter int unsigned PFN_W  = 40,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned OFF_W = 12,
    localparam int unsigned VPN_W = VA_W - OFF_W,
    localparam int unsigned PA_W  = PFN_W + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_va,
    input logic              req_ready,
    input logic              hash_req,
    input logic [VPN_W-1:0]  hash_key,
    input logic              hash_rsp_valid,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rsp_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_fault,
    input logic [PA_W-1:0]   rsp_pa
);
    logic [OFF_W-1:0] seen_off;
    logic [VA_W-1:0]  seen_va;
    logic             unused_va;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_off <= '0;
            seen_va  <= '0;
        end else if (req_valid && req_ready) begin
            seen_off <= req_va[OFF_W-1:0];
            seen_va  <= req_va;
        end
    end
    assign unused_va = ^seen_va[OFF_W-1:0];

    a_r1_key_is_base: assert property (@(posedge clk) disable iff (!rst_n)
        hash_req |-> (hash_key[3:0] == 4'd0) && (hash_key[VPN_W-1:4] == seen_va[VA_W-1:OFF_W+4]));

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_pa[OFF_W-1:0] == seen_off);

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_fault));

    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req && !hash_req && !rsp_valid);

    a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_pa == '0);

    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> mem_req && $stable(mem_addr));

    a_r10_hash_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hash_req && !hash_rsp_valid) |=> hash_req && $stable(hash_key));

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hash_req && mem_req));
endmodule

bind cpt_lookup_engine cpt_lookup_checker #(
    .VA_W(VA_W), .PFN_W(PFN_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_ready(req_ready), .hash_req(hash_req), .hash_key(hash_key),
    .hash_rsp_valid(hash_rsp_valid), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
);

// File: tb/cpt_lookup_engine_bench.sv
module cpt_lookup_engine_bench;
    localparam int unsigned VA_W = 48, PFN_W = 40, ADDR_W = 32, MAXD = 8;
    localparam int unsigned VPN_W = VA_W - 12, PA_W = PFN_W + 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [VA_W-1:0]   req_va = '0;
    logic              req_ready, hash_req, mem_req;
    logic [VPN_W-1:0]  hash_key;
    logic              hash_rsp_valid = 1'b0;
    logic [ADDR_W-1:0] hash_ptr = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [63:0]       mem_rdata = '0;
    logic              rsp_valid, rsp_hit, rsp_fault;
    logic [PA_W-1:0]   rsp_pa;
    logic [23:0]       rsp_ctrl;

    always #5 clk = ~clk;

    cpt_lookup_engine #(.VA_W(VA_W), .PFN_W(PFN_W), .ADDR_W(ADDR_W), .MAX_DEPTH(MAXD)) u_cpt_lookup_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
        .hash_req(hash_req), .hash_key(hash_key), .hash_rsp_valid(hash_rsp_valid), .hash_ptr(hash_ptr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_ctrl(rsp_ctrl)
    );

    int n_chk = 0, n_bad = 0;

    typedef struct {
        logic            hit;
        logic [PA_W-1:0] pa;
        logic [23:0]     ctrl;
        int              reads;
        string           req;
    } exp_t;
    exp_t sb_q[$];

    logic [63:0]  tbl [int unsigned];
    int unsigned  heads [16];
    int           lat = 0;
    int           wcnt = 0;
    logic [ADDR_W-1:0] held_addr = '0;
    int           rd_cnt = 0;

    function automatic logic [63:0] rd(input int unsigned a);
        return tbl.exists(a) ? tbl[a] : 64'd0;
    endfunction

    function automatic int hfn(input logic [VPN_W-1:0] k);
        return int'(k[7:4] ^ k[11:8]);
    endfunction

    // hash port model: answers one cycle after the request
    always @(negedge clk) begin
        hash_rsp_valid <= hash_req;
        hash_ptr       <= heads[hfn(hash_key)];
    end

    // memory model with programmable wait
    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt > 0) begin
                n_chk++;
                if (mem_addr !== held_addr) begin
                    n_bad++;
                    $display("FAIL R10 addr moved while waiting: got %h exp %h", mem_addr, held_addr);
                end
            end
            held_addr <= mem_addr;
            if (wcnt >= lat) begin
                mem_rsp_valid <= 1'b1;
                mem_rdata     <= rd(mem_addr);
                wcnt          <= 0;
            end else begin
                mem_rsp_valid <= 1'b0;
                wcnt          <= wcnt + 1;
            end
        end else begin
            mem_rsp_valid <= 1'b0;
            wcnt          <= 0;
        end
    end

    always @(posedge clk) begin
        if (req_valid && req_ready) rd_cnt <= 0;
        else if (mem_req && mem_rsp_valid) rd_cnt <= rd_cnt + 1;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rsp_valid) begin
            exp_t e;
            n_chk++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R9 unexpected response: got hit=%0b exp none", rsp_hit);
            end else begin
                e = sb_q.pop_front();
                if (rsp_hit !== e.hit || rsp_fault !== !e.hit || rsp_pa !== e.pa ||
                    rsp_ctrl !== e.ctrl || rd_cnt != e.reads)
                begin
                    n_bad++;
                    $display("FAIL %s got hit=%0b pa=%h ctrl=%h reads=%0d exp hit=%0b pa=%h ctrl=%h reads=%0d",
                             e.req, rsp_hit, rsp_pa, rsp_ctrl, rd_cnt, e.hit, e.pa, e.ctrl, e.reads);
                end
            end
        end
    end

    task automatic add_entry(input int idx, input logic [VPN_W-1:0] base,
                             input logic [15:0] map, input logic [3:0] size_m1);
        int unsigned p = 32'h100 + idx * 32;
        logic [39:0] seed = 40'hA0_0000_0000 + (40'(idx) << 8);
        tbl[p]      = 64'(base);
        tbl[p + 1]  = {20'h0, 24'hC00000 | 24'(idx), size_m1, map};
        for (int s = 0; s < 16; s++) tbl[p + 2 + s] = 64'(seed + 40'(s));
        tbl[p + 18] = 64'(heads[hfn(base)]);
        heads[hfn(base)] = p;
    endtask

    // independent reference walk over the bench's own table
    function automatic exp_t ref_walk(input logic [VA_W-1:0] va, input string req);
        exp_t e;
        logic [VPN_W-1:0] vpn  = va[VA_W-1:12];
        logic [VPN_W-1:0] base = {vpn[VPN_W-1:4], 4'h0};
        int               slot = int'(vpn[3:0]);
        int unsigned      p    = heads[hfn(base)];
        int               d    = 0;
        logic [63:0]      st;
        e.hit = 0; e.pa = '0; e.ctrl = '0; e.reads = 0; e.req = req;
        while (p != 0) begin
            d++; e.reads++;
            if (rd(p)[VPN_W-1:0] == base) begin
                e.reads++;
                st = rd(p + 1);
                if (st[slot] && slot <= int'(st[19:16])) begin
                    e.reads++;
                    e.hit  = 1;
                    e.ctrl = st[43:20];
                    e.pa   = {rd(p + 2 + slot)[PFN_W-1:0], va[11:0]};
                end
                return e;
            end
            if (d == MAXD) return e;
            e.reads++;
            p = rd(p + 18)[ADDR_W-1:0];
        end
        return e;
    endfunction

    task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [11:0] off, input string req);
        logic [VA_W-1:0] va = {vpn, off};
        sb_q.push_back(ref_walk(va, req));
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        @(negedge clk);
        req_valid = 1'b0;
        n_chk++;
        if (req_ready !== 1'b0 || hash_req !== 1'b1 || hash_key !== {vpn[VPN_W-1:4], 4'h0}) begin
            n_bad++;
            $display("FAIL R1 key/busy: got ready=%0b hreq=%0b key=%h exp ready=0 hreq=1 key=%h",
                     req_ready, hash_req, hash_key, {vpn[VPN_W-1:4], 4'h0});
        end
        while (!rsp_valid) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: lookup never completed, got hang exp done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < 16; b++) heads[b] = 0;
        // bucket 1 chain: C(0x3010) -> B(0x2010) -> A(0x1010)
        add_entry(0, 36'h1010, 16'hFFFF, 4'd15);
        add_entry(1, 36'h2010, 16'hFFDF, 4'd15);
        add_entry(2, 36'h3010, 16'hFFFF, 4'd7);
        // bucket 3 chain of ten: k=10 at head, k=1 deepest
        for (int k = 1; k <= 10; k++) add_entry(2 + k, VPN_W'(k * 36'h1000 + 36'h30), 16'hFFFF, 4'd15);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_req !== 1'b0 || hash_req !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 reset state: got ready=%0b rsp=%0b mreq=%0b hreq=%0b exp 1 0 0 0",
                     req_ready, rsp_valid, mem_req, hash_req);
        end

        lookup(36'h3017, 12'h5A5, "R2 hit head slot7");
        lookup(36'h3018, 12'h001, "R4 slot above size");
        lookup(36'h2015, 12'h123, "R3 bitmap clear");
        lookup(36'h2016, 12'hFFF, "R6 hit depth2");
        lookup(36'h1010, 12'h000, "R6 hit depth3 slot0");
        lookup(36'h101F, 12'hABC, "R8 hit depth3 slot15");
        lookup(36'h4013, 12'h010, "R5 chain end null");
        lookup(36'h0025, 12'h777, "R5 empty bucket");
        lookup(36'hA03C, 12'h321, "R2 hit head of long chain");
        lookup(36'h3032, 12'h456, "R7 hit at max depth");
        lookup(36'h1031, 12'h654, "R7 stop past max depth");
        lat = 2;
        lookup(36'h1019, 12'h888, "R10 hit with slow memory");
        lookup(36'h2015, 12'h999, "R3 fault with slow memory");
        lookup(36'h3032, 12'h0F0, "R8 reads at depth8 slow");
        lat = 1;
        lookup(36'h4013, 12'h111, "R5 null slow");

        repeat (4) @(negedge clk);
        n_chk++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R9 missing responses: got %0d left exp 0", sb_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule